// File: doc/BRIEF.md
# CCD Line and Frame Timing Generator

This block counts master clock cycles and produces the line and frame framing that the sequencers of an interline, progressive-scan CCD camera need. With the default setup, one line lasts 1790 master clocks at 28.636 MHz. A frame lasts 1068 lines in full progressive readout, which is about 1/15 s. It lasts 534 lines in either of the two high frame rate modes, which is about 1/30 s.

The block drives four kinds of output:
- an active-low line sync of programmable width;
- an active-low frame sync that covers the whole of line 0;
- a frame-start strobe;
- the live column and line counters, plus flags that mark horizontal blanking, optical-black pixels and effective pixels.

A readout-mode request can arrive at any time. It is caught in a shadow register. The active mode takes the shadowed value only when a new frame starts. A line therefore never changes length or layout partway through a frame.

Top module: `ccd_frame_timer`

## Requirements
- R1: `col_o` counts 0, 1, … up to LINE_CLKS-1 (1790 clocks by default). It then returns to 0.
- R2: `line_o` advances by one each time the column counter wraps. It returns to 0 after 1068 lines (LINES_PROG) while the active mode is 0, and after 534 lines (LINES_FAST) while the active mode is 1 or 2.
- R3: `fstart_o` is high in exactly those cycles where both counters are 0.
- R4: `hd_n_o` is low exactly while `col_o` is less than `hd_len_i`. A width of 0 gives no pulse.
- R5: `vd_n_o` is low for every cycle of line 0 and high on all other lines.
- R6: The mode codes are 0 for full progressive readout, 1 for high frame rate readout and 2 for high frame rate readout with two-line summing. A request with code 3 is ignored, and the pending mode keeps its previous value.
- R7: `mode_o` shows the active mode. A request made during a frame is applied at the next frame start, so `mode_o` changes only in a cycle where `fstart_o` is high.
- R8: `hblank_o` is high for the first H_START = LINE_CLKS − 1454 columns of each line (columns 0..335 by default).
- R9: The columns after blanking are, in order: 20 dummy bits, 2 optical-black pixels, 1392 effective pixels, then 40 optical-black pixels that run up to the end of the line.
- R10: In mode 0 the last rows of the frame are, in order: 8 optical-black rows, 1040 effective rows, then 2 optical-black rows that end the frame. All earlier rows, including 3 dummy rows, carry neither flag.
- R11: In modes 1 and 2 each vertical region count is halved: 4 optical-black rows, 520 effective rows, then 1 optical-black row that ends the frame.
- R12: `eff_o` is high where both the column and the row are effective. `ob_o` is high where the column is optical black or effective, the row is optical black or effective, and the pixel is not effective. The two flags are never high together.
- R13: A synchronous reset clears both counters to 0 and sets both the active and the pending mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Requested readout mode |
| hd_len_i | input | HDW | Line sync low width in clocks |
| hd_n_o | output | 1 | Line sync, active low |
| vd_n_o | output | 1 | Frame sync, active low |
| fstart_o | output | 1 | Frame-start strobe |
| col_o | output | CW | Column counter |
| line_o | output | LW | Line counter |
| mode_o | output | 2 | Active readout mode |
| hblank_o | output | 1 | Horizontal blanking flag |
| ob_o | output | 1 | Optical-black pixel flag |
| eff_o | output | 1 | Effective pixel flag |

## Verification
The bench runs a shrunken geometry and compares every output in every cycle against a position computed from the elapsed clock count since the last frame start.

It walks through each of the three modes with whole frames. This shows that the frame length and the vertical layout follow the active mode and not the requested one.

Some requests land mid-frame. This separates immediate switching from deferred switching, and one such request uses the illegal code 3.

The line sync width is swept across zero and nonzero values. A reset in the middle of a frame, with a request pending, shows that the pending mode is cleared and then taken up again.

// File: rtl/ccd_frame_timer.sv
module ccd_frame_timer #(
  parameter int LINE_CLKS  = 1790,
  parameter int H_DUMMY    = 20,
  parameter int H_OBF      = 2,
  parameter int H_EFF      = 1392,
  parameter int H_OBR      = 40,
  parameter int V_OBF      = 8,
  parameter int V_EFF      = 1040,
  parameter int V_OBR      = 2,
  parameter int LINES_PROG = 1068,
  parameter int LINES_FAST = 534,
  parameter int HDW        = 8,
  parameter int CW         = $clog2(LINE_CLKS),
  parameter int LW         = $clog2(LINES_PROG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode_i,
  input  logic [HDW-1:0] hd_len_i,
  output logic           hd_n_o,
  output logic           vd_n_o,
  output logic           fstart_o,
  output logic [CW-1:0]  col_o,
  output logic [LW-1:0]  line_o,
  output logic [1:0]     mode_o,
  output logic           hblank_o,
  output logic           ob_o,
  output logic           eff_o
);
  localparam int H_START = LINE_CLKS - H_DUMMY - H_OBF - H_EFF - H_OBR;
  localparam logic [CW-1:0] C_START = CW'(H_START);
  localparam logic [CW-1:0] C_OB0   = CW'(H_START + H_DUMMY);
  localparam logic [CW-1:0] C_EF0   = CW'(H_START + H_DUMMY + H_OBF);
  localparam logic [CW-1:0] C_OB1   = CW'(H_START + H_DUMMY + H_OBF + H_EFF);
  localparam logic [CW-1:0] C_LAST  = CW'(LINE_CLKS - 1);

  localparam int P_OB0 = LINES_PROG - V_OBR - V_EFF - V_OBF;
  localparam int F_OB0 = LINES_FAST - V_OBR / 2 - V_EFF / 2 - V_OBF / 2;
  localparam logic [LW-1:0] P_LAST = LW'(LINES_PROG - 1);
  localparam logic [LW-1:0] F_LAST = LW'(LINES_FAST - 1);

  logic [1:0]    shadow;
  logic          fast, last_col, last_line;
  logic [LW-1:0] r_ob0, r_ef0, r_ob1;
  logic          h_ob, h_ef, v_ob, v_ef;

  assign fast      = (mode_o != 2'b00);
  assign last_col  = (col_o == C_LAST);
  assign last_line = (line_o == (fast ? F_LAST : P_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o  <= '0;
      line_o <= '0;
      mode_o <= 2'b00;
      shadow <= 2'b00;
    end else begin
      if (mode_i != 2'b11) shadow <= mode_i;
      col_o <= last_col ? '0 : col_o + CW'(1);
      if (last_col) begin
        line_o <= last_line ? '0 : line_o + LW'(1);
        if (last_line) mode_o <= shadow;
      end
    end
  end

  assign r_ob0 = fast ? LW'(F_OB0) : LW'(P_OB0);
  assign r_ef0 = fast ? LW'(F_OB0 + V_OBF / 2) : LW'(P_OB0 + V_OBF);
  assign r_ob1 = fast ? LW'(F_OB0 + V_OBF / 2 + V_EFF / 2) : LW'(P_OB0 + V_OBF + V_EFF);

  assign h_ef = (col_o >= C_EF0) && (col_o < C_OB1);
  assign h_ob = ((col_o >= C_OB0) && (col_o < C_EF0)) || (col_o >= C_OB1);
  assign v_ef = (line_o >= r_ef0) && (line_o < r_ob1);
  assign v_ob = ((line_o >= r_ob0) && (line_o < r_ef0)) || (line_o >= r_ob1);

  assign eff_o    = h_ef && v_ef;
  assign ob_o     = (h_ob || h_ef) && (v_ob || v_ef) && !(h_ef && v_ef);
  assign hblank_o = (col_o < C_START);
  assign hd_n_o   = !(32'(col_o) < 32'(hd_len_i));
  assign vd_n_o   = (line_o != '0);
  assign fstart_o = (col_o == '0) && (line_o == '0);
endmodule

// File: rtl/ccd_frame_timer_chk.sv
module ccd_frame_timer_chk #(
  parameter int LINE_CLKS = 1790,
  parameter int CW        = 11,
  parameter int LW        = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          vd_n_o,
  input logic          fstart_o,
  input logic [CW-1:0] col_o,
  input logic [LW-1:0] line_o,
  input logic [1:0]    mode_o,
  input logic          hblank_o,
  input logic          ob_o,
  input logic          eff_o
);
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst) 32'(col_o) < LINE_CLKS); // R1
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (32'(col_o) != LINE_CLKS - 1) |=> (col_o == $past(col_o) + CW'(1))); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (32'(col_o) != LINE_CLKS - 1) |=> $stable(line_o)); // R2
  AST_VD_AT_START: assert property (@(posedge clk) disable iff (rst) $fell(vd_n_o) |-> fstart_o); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) mode_o != 2'b11); // R6
  AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (rst) !fstart_o |-> $stable(mode_o)); // R7
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst) hblank_o |-> !(ob_o || eff_o)); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst) !(ob_o && eff_o)); // R12
endmodule

bind ccd_frame_timer ccd_frame_timer_chk #(.LINE_CLKS(LINE_CLKS), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .vd_n_o(vd_n_o), .fstart_o(fstart_o), .col_o(col_o),
  .line_o(line_o), .mode_o(mode_o), .hblank_o(hblank_o), .ob_o(ob_o), .eff_o(eff_o));

// File: tb/test_ccd_frame_timer.sv
module test_ccd_frame_timer;
  localparam int CLK_PERIOD = 10;
  localparam int L = 40, LP = 20, LF = 10;
  localparam int HS = 13, HO0 = 15, HE0 = 16, HO1 = 36;
  localparam int PO0 = 8, PE0 = 10, PO1 = 18;
  localparam int FO0 = 4, FE0 = 5, FO1 = 9;

  logic clk = 0, rst = 1;
  logic [1:0] mode_i = 0;
  logic [7:0] hd_len_i = 3;
  logic hd_n_o, vd_n_o, fstart_o, hblank_o, ob_o, eff_o;
  logic [5:0] col_o;
  logic [4:0] line_o;
  logic [1:0] mode_o;

  int total = 0, bad = 0;
  int fpos = 0, exp_mode = 0, pend = 0;
  bit valid = 0, done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_frame_timer #(.LINE_CLKS(L), .H_DUMMY(2), .H_OBF(1), .H_EFF(20), .H_OBR(4),
    .V_OBF(2), .V_EFF(8), .V_OBR(2), .LINES_PROG(LP), .LINES_FAST(LF), .HDW(8)) i_ccd_frame_timer (
    .clk(clk), .rst(rst), .mode_i(mode_i), .hd_len_i(hd_len_i), .hd_n_o(hd_n_o), .vd_n_o(vd_n_o),
    .fstart_o(fstart_o), .col_o(col_o), .line_o(line_o), .mode_o(mode_o),
    .hblank_o(hblank_o), .ob_o(ob_o), .eff_o(eff_o));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (fpos=%0d mode=%0d)", req, act, exp, fpos, exp_mode);
    end
  endtask

  task automatic cycle();
    int c, r, o0, e0, o1, hob, hef, vob, vef;
    string vt;
    if (valid) begin
      c = fpos % L; r = fpos / L;
      o0 = exp_mode == 0 ? PO0 : FO0;
      e0 = exp_mode == 0 ? PE0 : FE0;
      o1 = exp_mode == 0 ? PO1 : FO1;
      vt = exp_mode == 0 ? "R10" : "R11";
      hef = int'(c >= HE0 && c < HO1);
      hob = int'((c >= HO0 && c < HE0) || c >= HO1);
      vef = int'(r >= e0 && r < o1);
      vob = int'((r >= o0 && r < e0) || r >= o1);
      chk("R1 column", int'(col_o), c);
      chk("R2 line", int'(line_o), r);
      chk("R3 frame strobe", int'(fstart_o), int'(fpos == 0));
      chk("R4 line sync", int'(hd_n_o), int'(c >= int'(hd_len_i)));
      chk("R5 frame sync", int'(vd_n_o), int'(r != 0));
      chk("R6 R7 active mode", int'(mode_o), exp_mode);
      chk("R8 hblank", int'(hblank_o), int'(c < HS));
      chk({"R9 R12 effective ", vt}, int'(eff_o), hef & vef);
      chk({"R9 R12 optical black ", vt}, int'(ob_o), (hob | hef) & (vob | vef) & ~(hef & vef));
    end
    if (rst) begin
      valid = 1; fpos = 0; exp_mode = 0; pend = 0;
    end else begin
      fpos++;
      if (fpos == L * (exp_mode == 0 ? LP : LF)) begin
        fpos = 0; exp_mode = pend;
      end
      if (mode_i != 2'b11) pend = int'(mode_i);
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle(); cycle();
    // R13 reset state
    chk("R13 reset col", int'(col_o), 0);
    chk("R13 reset line", int'(line_o), 0);
    chk("R13 reset mode", int'(mode_o), 0);
    rst = 0;
    run(900);
    run(130);  mode_i = 1;  run(1800);
    run(90);   mode_i = 3;  run(900);
    hd_len_i = 0; run(50); mode_i = 2; run(1000);
    hd_len_i = 7; run(120); mode_i = 0; run(1700);
    mode_i = 1; run(250);
    rst = 1; cycle(); cycle();
    chk("R13 mid-frame reset mode", int'(mode_o), 0);
    chk("R13 mid-frame reset line", int'(line_o), 0);
    rst = 0;
    run(1300);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule